// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits behind a two-wire serial slave front end and in front of a byte-wide nonvolatile array model. It collects the data bytes of one write transaction into a small page latch. The first byte of a transaction carries the full array address. Each later byte goes to the next slot of the same page, and the slot number wraps inside the page.

When the transaction ends with a stop condition after at least one whole data byte, the block starts a timed programming cycle. During that cycle it copies the latched bytes into the array through a single write port and holds a busy flag. The front end uses busy to withhold acknowledges. A write-protect input can inhibit writes to the upper half of the array. The page length, the array address width, whether protection exists, and the system clock rate are all parameters.

Top module: `pwb_seq_top`

## Requirements
- R1: After reset, busy_o is low and mem_we_o is low.
- R2: A transaction holding exactly one byte is programmed at the address given with that byte. busy_o rises in the cycle after the stop and stays high for exactly CLK_KHZ*1000/1000 cycles, which is 1 ms.
- R3: The slot of the first byte is the low log2(PAGE_BYTES) bits of its address, and each later byte takes the next slot modulo PAGE_BYTES. During programming the written slots appear on the array port in ascending slot order, one per cycle, with mem_addr_o = {page bits of the first address, slot}.
- R4: A transaction of N>=2 bytes keeps busy_o high for N*CLK_KHZ*400/1000 cycles, which is 0.4 ms per byte.
- R5: When more than PAGE_BYTES bytes arrive, later data overwrites the earlier data in the same slot. N then saturates at PAGE_BYTES for timing.
- R6: A stop that arrives with stop_partial_i high (part-way through a byte) discards the transaction. busy_o stays low and nothing is written.
- R7: A stop with no latched byte has no effect: busy_o stays low.
- R8: Byte strobes that arrive while busy_o is high are ignored. A later stop on its own therefore starts no programming.
- R9: With PROTECT_EN=1, when wp_i is high as the first byte arrives and the top address bit of that byte is 1, no array write is made. busy_o still follows R2/R4. A page in the lower half, or wp_i low, is written normally.
- R10: A byte marked wr_first_i in the middle of a transaction restarts the latch. Only bytes from the new first byte onward are programmed.
- R11: mem_we_o is only ever high while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb_i | input | 1 | One complete data byte received |
| wr_first_i | input | 1 | This byte is the first of a transaction and carries the address |
| wr_addr_i | input | ADDR_W | Array address (used on the first byte) |
| wr_data_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop condition seen on the bus |
| stop_partial_i | input | 1 | The stop came part-way through a byte |
| wp_i | input | 1 | Hardware write-protect pin |
| busy_o | output | 1 | Programming cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The bench builds the block with ADDR_W=9, PAGE_BYTES=8, PROTECT_EN=1 and CLK_KHZ=20. With these values a single-byte cycle lasts 20 clocks and a page cycle lasts 8 clocks per byte. The full timing rule, including the saturated 64-clock case, therefore fits in a short run. The eight-slot page lets the bench start a write mid-page and overrun it by two bytes to exercise the wrap. The nine-bit address places a protected half above 0x100, which both states of the protect input can reach.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_FILL = 2'd1,
        PS_PROG = 2'd2
    } pwb_state_e;

    localparam int SINGLE_US   = 1000;
    localparam int PER_BYTE_US = 400;
endpackage

// File: rtl/pwb_wp_decode.sv
`timescale 1ns/1ps
module pwb_wp_decode #(
    parameter int ADDR_W     = 8,
    parameter int PROTECT_EN = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_i,
    output logic              prot_o
);
    generate
        if (PROTECT_EN != 0) begin : g_prot
            assign prot_o = wp_i & addr_i[ADDR_W-1];
        end else begin : g_noprot
            logic unused_w;
            assign unused_w = wp_i ^ (^addr_i);
            assign prot_o   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pwb_prog_timer.sv
`timescale 1ns/1ps
module pwb_prog_timer #(
    parameter int DUR_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             done_o
);
    typedef struct packed {
        logic [DUR_W-1:0] rem;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.rem = dur_i - DUR_W'(1);
        end else if (tmr_q.rem != '0) begin
            tmr_d.rem = tmr_q.rem - DUR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done_o = (tmr_q.rem == '0);

    AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && dur_i > DUR_W'(1)) |=> !done_o); // R2
endmodule

// File: rtl/pwb_page_latch.sv
`timescale 1ns/1ps
module pwb_page_latch #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 2,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W,
    localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              push_i,
    input  logic              first_i,
    input  logic              keep_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic [OFF_W-1:0]  rd_slot_i,
    output logic [PG_W-1:0]   page_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              rd_valid_o,
    output logic [7:0]        rd_data_o
);
    typedef struct packed {
        logic [PG_W-1:0]             page;
        logic [OFF_W-1:0]            ptr;
        logic [CNT_W-1:0]            count;
        logic [PAGE_BYTES-1:0]       valid;
        logic [PAGE_BYTES-1:0][7:0]  data;
    } lat_t;

    lat_t lat_d, lat_q;
    logic [OFF_W-1:0] slot;

    always_comb begin
        lat_d = lat_q;
        slot  = lat_q.ptr;
        if (clr_i) begin
            lat_d.valid = '0;
            lat_d.count = '0;
            lat_d.ptr   = '0;
        end else if (push_i) begin
            if (first_i) begin
                lat_d.valid = '0;
                lat_d.page  = addr_i[ADDR_W-1:OFF_W];
                slot        = addr_i[OFF_W-1:0];
                lat_d.count = CNT_W'(1);
            end else if (lat_q.count < CNT_W'(PAGE_BYTES)) begin
                lat_d.count = lat_q.count + CNT_W'(1);
            end
            if (keep_i) begin
                lat_d.data[slot]  = data_i;
                lat_d.valid[slot] = 1'b1;
            end
            lat_d.ptr = slot + OFF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign page_o     = lat_q.page;
    assign count_o    = lat_q.count;
    assign rd_valid_o = lat_q.valid[rd_slot_i];
    assign rd_data_o  = lat_q.data[rd_slot_i];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(PAGE_BYTES)); // R5
    AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !first_i && !clr_i && count_o < CNT_W'(PAGE_BYTES))
        |=> count_o == $past(count_o) + CNT_W'(1)); // R3
endmodule

// File: rtl/pwb_seq_top.sv
`timescale 1ns/1ps
module pwb_seq_top
    import pwb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 2,
    parameter int PROTECT_EN = 1,
    parameter int CLK_KHZ    = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic              wr_first_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              stop_i,
    input  logic              stop_partial_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o
);
    localparam int OFF_W    = $clog2(PAGE_BYTES);
    localparam int PG_W     = ADDR_W - OFF_W;
    localparam int CNT_W    = $clog2(PAGE_BYTES + 1);
    localparam int BYTE_CYC = CLK_KHZ * SINGLE_US / 1000;
    localparam int PAGE_CYC = CLK_KHZ * PER_BYTE_US / 1000;
    localparam int PAGE_MAX = PAGE_BYTES * PAGE_CYC;
    localparam int DUR_MAX  = (BYTE_CYC > PAGE_MAX) ? BYTE_CYC : PAGE_MAX;
    localparam int DUR_W    = $clog2(DUR_MAX + 1);

    typedef struct packed {
        pwb_state_e     state;
        logic           prot;
        logic [OFF_W:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             prot_now;
    logic             push;
    logic             first_eff;
    logic             keep;
    logic             clr;
    logic             load;
    logic             tmr_done;
    logic [DUR_W-1:0] dur;
    logic [PG_W-1:0]  page;
    logic [CNT_W-1:0] count;
    logic             rd_valid;
    logic [7:0]       rd_data;

    pwb_wp_decode #(
        .ADDR_W     (ADDR_W),
        .PROTECT_EN (PROTECT_EN)
    ) wp_i0 (
        .addr_i (wr_addr_i),
        .wp_i   (wp_i),
        .prot_o (prot_now)
    );

    pwb_page_latch #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) latch_i0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .push_i     (push),
        .first_i    (first_eff),
        .keep_i     (keep),
        .addr_i     (wr_addr_i),
        .data_i     (wr_data_i),
        .rd_slot_i  (seq_q.idx[OFF_W-1:0]),
        .page_o     (page),
        .count_o    (count),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );

    pwb_prog_timer #(
        .DUR_W (DUR_W)
    ) tmr_i0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .dur_i  (dur),
        .done_o (tmr_done)
    );

    always_comb begin
        if (count == CNT_W'(1)) dur = DUR_W'(BYTE_CYC);
        else                    dur = DUR_W'(count) * DUR_W'(PAGE_CYC);
    end

    always_comb begin
        seq_d     = seq_q;
        push      = wr_stb_i && !stop_i && (seq_q.state != PS_PROG);
        first_eff = wr_first_i || (seq_q.state == PS_IDLE);
        keep      = first_eff ? !prot_now : !seq_q.prot;
        clr       = 1'b0;
        load      = 1'b0;
        if (push && first_eff) begin
            seq_d.prot = prot_now;
        end
        case (seq_q.state)
            PS_IDLE: begin
                if (push) seq_d.state = PS_FILL;
            end
            PS_FILL: begin
                if (stop_i) begin
                    if (stop_partial_i) begin
                        clr         = 1'b1;
                        seq_d.state = PS_IDLE;
                    end else begin
                        load        = 1'b1;
                        seq_d.idx   = '0;
                        seq_d.state = PS_PROG;
                    end
                end
            end
            PS_PROG: begin
                if (seq_q.idx < (OFF_W+1)'(PAGE_BYTES)) begin
                    seq_d.idx = seq_q.idx + (OFF_W+1)'(1);
                end
                if (tmr_done) begin
                    clr         = 1'b1;
                    seq_d.state = PS_IDLE;
                end
            end
            default: seq_d.state = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: PS_IDLE, prot: 1'b0, idx: '0};
        else        seq_q <= seq_d;
    end

    assign busy_o      = (seq_q.state == PS_PROG);
    assign mem_we_o    = busy_o && (seq_q.idx < (OFF_W+1)'(PAGE_BYTES))
                         && rd_valid && !seq_q.prot;
    assign mem_addr_o  = {page, seq_q.idx[OFF_W-1:0]};
    assign mem_wdata_o = rd_data;

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i)); // R2
    AST_PARTIAL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && stop_partial_i && !busy_o) |=> !busy_o); // R6
    AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && count == '0 && !busy_o) |=> !busy_o); // R7
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_stb_i && !tmr_done) |=> $stable(count)); // R8
    AST_WE_IN_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> count != '0); // R11
endmodule

// File: tb/pwb_seq_top_tb.sv
`timescale 1ns/1ps
module pwb_seq_top_tb_top;
    localparam int AW = 9;
    localparam int PB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0, wr_first = 1'b0, stop = 1'b0, partial = 1'b0, wp = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    logic [16:0] expq[$];

    logic [7:0] m_data [PB];
    logic       m_valid [PB];
    int         m_cnt, m_ptr, m_page;
    logic       m_prot, m_active;

    always #5 clk = ~clk;

    pwb_seq_top #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROTECT_EN(1), .CLK_KHZ(20)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_first_i(wr_first),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .stop_i(stop),
        .stop_partial_i(partial), .wp_i(wp), .busy_o(busy), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata));

    // monitor: every array write must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected write: actual %h/%h expected none", cur_tag, mem_addr, mem_wdata);
            end else begin
                logic [16:0] e;
                e = expq.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    errors++;
                    $display("FAIL %s write: actual %h/%h expected %h/%h", cur_tag,
                             mem_addr, mem_wdata, e[16:8], e[7:0]);
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < PB; i++) m_valid[i] = 1'b0;
        m_cnt = 0; m_ptr = 0; m_prot = 1'b0; m_active = 1'b0;
    endtask

    task automatic send(input logic first, input logic [AW-1:0] a, input logic [7:0] d);
        int slot;
        @(negedge clk);
        wr_stb = 1'b1; wr_first = first; wr_addr = a; wr_data = d;
        if (first || !m_active) begin
            for (int i = 0; i < PB; i++) m_valid[i] = 1'b0;
            m_page = int'(a[AW-1:3]); slot = int'(a[2:0]); m_cnt = 1;
            m_prot = wp && a[AW-1]; m_active = 1'b1;
        end else begin
            slot = m_ptr;
            if (m_cnt < PB) m_cnt++;
        end
        if (!m_prot) begin m_data[slot] = d; m_valid[slot] = 1'b1; end
        m_ptr = (slot + 1) % PB;
        @(negedge clk);
        wr_stb = 1'b0; wr_first = 1'b0;
    endtask

    task automatic finish(input logic part, input logic stray, input string tag);
        int exp_dur, n;
        cur_tag = tag;
        exp_dur = 0;
        if (m_active && !part) begin
            exp_dur = (m_cnt == 1) ? 20 : m_cnt * 8;
            if (!m_prot)
                for (int i = 0; i < PB; i++)
                    if (m_valid[i]) expq.push_back({m_page[5:0], i[2:0], m_data[i]});
        end
        @(negedge clk);
        stop = 1'b1; partial = part;
        @(negedge clk);
        stop = 1'b0; partial = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            wr_stb = stray && (n == 3);
            wr_first = wr_stb; wr_addr = 9'h011; wr_data = 8'hEE;
            @(negedge clk);
        end
        wr_stb = 1'b0; wr_first = 1'b0;
        repeat (3) @(negedge clk);
        check({tag, " busy length"}, n, exp_dur);
        check({tag, " pending writes"}, expq.size(), 0);
        expq.delete();
        model_reset();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 we after reset", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: single byte, 20-cycle programming
        send(1'b1, 9'h023, 8'h5A);
        finish(1'b0, 1'b0, "R2");

        // R3 / R4: three bytes from slot 5, 24 cycles
        send(1'b1, 9'h0A5, 8'h11);
        send(1'b0, 9'h000, 8'h22);
        send(1'b0, 9'h000, 8'h33);
        finish(1'b0, 1'b0, "R3_R4");

        // R4: two bytes, 16 cycles
        send(1'b1, 9'h040, 8'hA0);
        send(1'b0, 9'h000, 8'hA1);
        finish(1'b0, 1'b0, "R4");

        // R5: ten bytes from slot 6 wrap, saturate at 64 cycles
        for (int k = 0; k < 10; k++) send(k == 0, 9'h0F6, 8'(8'h80 + k));
        finish(1'b0, 1'b0, "R5");

        // R6: stop in the middle of a byte
        send(1'b1, 9'h030, 8'h77);
        finish(1'b1, 1'b0, "R6");
        // after discard the latch must be empty: a plain stop does nothing
        finish(1'b0, 1'b0, "R6_after");

        // R7: stop with nothing latched
        finish(1'b0, 1'b0, "R7");

        // R8: stray strobe during busy, then a bare stop
        send(1'b1, 9'h050, 8'h3C);
        finish(1'b0, 1'b1, "R8_prog");
        finish(1'b0, 1'b0, "R8");

        // R9: protection
        wp = 1'b1;
        send(1'b1, 9'h1C0, 8'hD0);
        send(1'b0, 9'h000, 8'hD1);
        finish(1'b0, 1'b0, "R9_protected");
        send(1'b1, 9'h0C0, 8'hD2);
        send(1'b0, 9'h000, 8'hD3);
        finish(1'b0, 1'b0, "R9_lower");
        wp = 1'b0;
        send(1'b1, 9'h1C0, 8'hD4);
        finish(1'b0, 1'b0, "R9_wp_low");

        // R10: restart mid transaction; R11 covered by monitor
        send(1'b1, 9'h068, 8'h01);
        send(1'b1, 9'h1A2, 8'h02);
        send(1'b0, 9'h000, 8'h03);
        finish(1'b0, 1'b0, "R10_R11");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule